// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is one 16-bit channel register that sits beside a 16-bit up-counter. A single mode bit decides its role.

In compare mode, the host owns the register and can both load it and read it. The block watches the counter value on every cycle and gives a one-cycle interrupt pulse when the counter comes to equal the stored value. In capture mode, the register takes a snapshot of the counter when a selected transition appears on one of two external input pins. While in this mode, host loads are dropped and the register can only be read.

The two pins decode their 2-bit edge-select fields differently. For the first pin, the field names the pin's active edge, and the capture happens on the opposite transition. The two upper codes of that field never capture. For the second pin, the code maps directly to the capturing edge, and its top code captures on either transition. A separate input tells the block that the counter restarts on a compare match. In that case a stored value of zero can never be reached, so the block raises a flag for it.

Top module: `tcc_channel`

## Requirements
- R1: After reset the register reads 0x0000 and the interrupt is low.
- R2: In compare mode (modeCapture=0), a host write with wrEn=1 loads wrData, and rdData shows it one clock later.
- R3: In compare mode, matchIrq is high for exactly one cycle, one clock after cntVal first equals the register. It stays low while that equality persists.
- R4: With the stored value 0x0000 and clearOnMatch=0, the counter stepping from 0xFFFF to 0x0000 raises the match pulse.
- R5: zeroCmpIllegal is 1 exactly when modeCapture=0, clearOnMatch=1 and the register holds 0x0000.
- R6: In capture mode (modeCapture=1), host writes leave the register unchanged and matchIrq stays low, even when cntVal equals the register.
- R7: With srcSel=0 (pin pinA), edgeSel0 works as follows: 00 captures on a rising pinA transition, 01 captures on a falling one, and 10 and 11 never capture.
- R8: With srcSel=1 (pin pinB), edgeSel1 works as follows: 00 captures on a falling transition, 01 on a rising one, 10 never, and 11 on both.
- R9: Each pin passes through a two-flop synchronizer. The captured value is the cntVal present at the third rising clock after the pin changes.
- R10: The pin that srcSel does not select has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCapture | input | 1 | 0 = compare role, 1 = capture role |
| srcSel | input | 1 | Capture source: 0 = pinA, 1 = pinB |
| edgeSel0 | input | 2 | Edge code for pinA |
| edgeSel1 | input | 2 | Edge code for pinB |
| clearOnMatch | input | 1 | Counter restarts on a compare match |
| cntVal | input | 16 | Current counter value |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 16 | Host write data |
| pinA | input | 1 | External capture pin 0 (asynchronous) |
| pinB | input | 1 | External capture pin 1 (asynchronous) |
| rdData | output | 16 | Register contents |
| matchIrq | output | 1 | One-cycle compare-match pulse |
| zeroCmpIllegal | output | 1 | Zero compare value in clear-on-match use |

## Verification
The assertions check four properties on every cycle:
- The match pulse never lasts two cycles, and it never appears in capture mode.
- The reserved pinA codes never produce a capture strobe.
- A capture always loads the counter value from the cycle it fired.
- The register holds when neither a capture nor a load is active.

Some behaviour depends on real pin waveforms and counter sequences, so only the bench scenarios can show it. This covers the inverted pinA edge mapping, the both-edge code on pinB, the exact three-clock capture latency, the pulse on the 0xFFFF-to-0x0000 wrap, and the isolation of the unselected pin.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned TCC_WIDTH = 16;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;   // latch counter value
    logic hostLoad;  // latch host write data
  } tccStrobe_t;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } tccEdge_t;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeCapture,
  input  logic       srcSel,
  input  logic [1:0] edgeSel0,
  input  logic [1:0] edgeSel1,
  input  logic       wrEn,
  input  logic       pinA,
  input  logic       pinB,
  input  logic       cmpEqual,
  output tccStrobe_t strb,
  output logic       matchIrq
);
  localparam int unsigned NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinFall;

  assign pinRaw = {pinB, pinA};

  // per-pin synchronizer chain and edge detector
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain      <= '0;
        pinPrev[p] <= 1'b0;
      end else begin
        chain      <= {chain[SYNC_STAGES-2:0], pinRaw[p]};
        pinPrev[p] <= chain[SYNC_STAGES-1];
      end
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
    assign pinRise[p] = pinSync[p] & ~pinPrev[p];
    assign pinFall[p] = ~pinSync[p] & pinPrev[p];
  end

  // pinA: code names the active level change, capture on the opposite one
  function automatic tccEdge_t decodePin0(input logic [1:0] code);
    case (code)
      2'b00:   return EDGE_RISE;
      2'b01:   return EDGE_FALL;
      default: return EDGE_NONE;
    endcase
  endfunction

  // pinB: code maps directly to the capturing transition
  function automatic tccEdge_t decodePin1(input logic [1:0] code);
    case (code)
      2'b00:   return EDGE_FALL;
      2'b01:   return EDGE_RISE;
      2'b11:   return EDGE_BOTH;
      default: return EDGE_NONE;
    endcase
  endfunction

  tccEdge_t edgeKind;
  logic     selRise;
  logic     selFall;
  logic     edgeHit;
  logic     matchHit;
  logic     eqPrev;

  always_comb begin
    if (srcSel) begin
      edgeKind = decodePin1(edgeSel1);
      selRise  = pinRise[1];
      selFall  = pinFall[1];
    end else begin
      edgeKind = decodePin0(edgeSel0);
      selRise  = pinRise[0];
      selFall  = pinFall[0];
    end
    edgeHit = (edgeKind[0] & selRise) | (edgeKind[1] & selFall);
  end

  assign strb.capture  = modeCapture & edgeHit;
  assign strb.hostLoad = wrEn & ~modeCapture & ~strb.capture;
  assign matchHit      = ~modeCapture & cmpEqual;

  // pulse only on arrival of equality; eqPrev resets high so reset never pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eqPrev   <= 1'b1;
      matchIrq <= 1'b0;
    end else begin
      eqPrev   <= matchHit;
      matchIrq <= matchHit & ~eqPrev;
    end
  end

  p_irq_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |=> !matchIrq);

  p_no_irq_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeCapture |=> !matchIrq);

  p_pin0_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!srcSel && edgeSel0[1]) |-> !strb.capture);

  p_pin1_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel && edgeSel1 == 2'b10) |-> !strb.capture);
endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int unsigned WIDTH = TCC_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  tccStrobe_t       strb,
  input  logic [WIDTH-1:0] cntVal,
  input  logic [WIDTH-1:0] wrData,
  input  logic             modeCapture,
  input  logic             clearOnMatch,
  output logic [WIDTH-1:0] cmpReg,
  output logic             cmpEqual,
  output logic             zeroIllegal
);
  localparam logic [WIDTH-1:0] ZERO_VAL = '0;

  // capture takes priority over a host load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmpReg <= ZERO_VAL;
    else if (strb.capture)  cmpReg <= cntVal;
    else if (strb.hostLoad) cmpReg <= wrData;
  end

  assign cmpEqual    = (cmpReg == cntVal);
  assign zeroIllegal = ~modeCapture & clearOnMatch & (cmpReg == ZERO_VAL);

  p_capture_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (cmpReg == $past(cntVal)));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.hostLoad) |=> $stable(cmpReg));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int unsigned WIDTH       = TCC_WIDTH,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeCapture,
  input  logic             srcSel,
  input  logic [1:0]       edgeSel0,
  input  logic [1:0]       edgeSel1,
  input  logic             clearOnMatch,
  input  logic [WIDTH-1:0] cntVal,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pinA,
  input  logic             pinB,
  output logic [WIDTH-1:0] rdData,
  output logic             matchIrq,
  output logic             zeroCmpIllegal
);
  tccStrobe_t strb;
  logic       cmpEqual;

  tcc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .modeCapture (modeCapture),
    .srcSel      (srcSel),
    .edgeSel0    (edgeSel0),
    .edgeSel1    (edgeSel1),
    .wrEn        (wrEn),
    .pinA        (pinA),
    .pinB        (pinB),
    .cmpEqual    (cmpEqual),
    .strb        (strb),
    .matchIrq    (matchIrq)
  );

  tcc_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cntVal       (cntVal),
    .wrData       (wrData),
    .modeCapture  (modeCapture),
    .clearOnMatch (clearOnMatch),
    .cmpReg       (rdData),
    .cmpEqual     (cmpEqual),
    .zeroIllegal  (zeroCmpIllegal)
  );

  p_wr_compare_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCapture && wrEn) |=> (rdData == $past(wrData)));

  p_wr_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeCapture && !strb.capture) |=> $stable(rdData));
endmodule

// File: tb/tcc_channel_tb_top.sv
`timescale 1ns/1ps
module tcc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        modeCapture, srcSel, clearOnMatch, wrEn, pinA, pinB;
  logic [1:0]  edgeSel0, edgeSel1;
  logic [15:0] cnt, wrData, rdData, cntInc, model;
  logic        matchIrq, zeroCmpIllegal;

  int nTests = 0;
  int nFail  = 0;
  int cycle  = 0;
  bit done   = 0;

  typedef struct {
    int          due;
    int          sig;   // 0 rdData, 1 matchIrq, 2 zeroCmpIllegal
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  tcc_channel dut_i (
    .clk(clk), .rstN(rstN), .modeCapture(modeCapture), .srcSel(srcSel),
    .edgeSel0(edgeSel0), .edgeSel1(edgeSel1), .clearOnMatch(clearOnMatch),
    .cntVal(cnt), .wrEn(wrEn), .wrData(wrData), .pinA(pinA), .pinB(pinB),
    .rdData(rdData), .matchIrq(matchIrq), .zeroCmpIllegal(zeroCmpIllegal)
  );

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cycle) begin
        logic [15:0] act;
        case (sb[i].sig)
          0:       act = rdData;
          1:       act = {15'd0, matchIrq};
          default: act = {15'd0, zeroCmpIllegal};
        endcase
        nTests++;
        if (act !== sb[i].val) begin
          nFail++;
          $display("FAIL %s: signal %0d actual %h expected %h",
                   sb[i].req, sb[i].sig, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expectAt(input int sig, input int k, input logic [15:0] v, input string req);
    exp_t e;
    e.due = cycle + k; e.sig = sig; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk); #1;
    cnt = cnt + cntInc;
  endtask

  // prime the pin in compare role, then toggle it in capture role
  task automatic capTest(input logic src, input int pinIdx, input logic lvl,
                         input logic [1:0] code, input logic hit, input string req);
    logic [15:0] expv;
    modeCapture = 1'b0; srcSel = src;
    if (pinIdx == 0) pinA = ~lvl; else pinB = ~lvl;
    cntInc = 16'd1;
    repeat (4) step();
    modeCapture = 1'b1; edgeSel0 = code; edgeSel1 = code;
    if (pinIdx == 0) pinA = lvl; else pinB = lvl;
    expv = hit ? cnt + 16'd2 : model;
    expectAt(0, 3, expv, req);
    if (hit) model = expv;
    repeat (5) step();
    cntInc = 16'd0; modeCapture = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; modeCapture = 0; srcSel = 0; clearOnMatch = 0; wrEn = 0;
    pinA = 0; pinB = 0; edgeSel0 = 0; edgeSel1 = 0; wrData = 0;
    cnt = 16'h1234; cntInc = 0; model = 0;
    repeat (3) step();
    rstN = 1'b1;
    expectAt(0, 1, 16'h0000, "R1");
    expectAt(1, 1, 16'h0000, "R1");
    step(); step();

    // R2 host load in compare role
    wrEn = 1; wrData = 16'h00A5;
    expectAt(0, 1, 16'h00A5, "R2");
    step(); wrEn = 0; step();

    // R3 single pulse on arrival of equality
    cnt = 16'h00A5;
    expectAt(1, 1, 16'h0001, "R3");
    expectAt(1, 2, 16'h0000, "R3");
    step(); step(); step();
    cnt = 16'h0010; step();

    // R4 zero compare value fires on wrap
    wrEn = 1; wrData = 16'h0000; step(); wrEn = 0;
    cnt = 16'hFFFF; step(); step();
    cnt = 16'h0000;
    expectAt(1, 1, 16'h0001, "R4");
    step(); step();
    cnt = 16'h0040; step();

    // R5 illegal zero in clear-on-match use
    clearOnMatch = 1;
    expectAt(2, 1, 16'h0001, "R5");
    step(); step();
    wrEn = 1; wrData = 16'h0005;
    expectAt(2, 1, 16'h0000, "R5");
    step(); wrEn = 0; clearOnMatch = 0; step();
    model = 16'h0005;

    // R6 capture role: writes dropped, no match pulse
    modeCapture = 1; wrEn = 1; wrData = 16'h7777;
    expectAt(0, 1, 16'h0005, "R6");
    step(); wrEn = 0;
    cnt = 16'h0005;
    expectAt(1, 1, 16'h0000, "R6");
    expectAt(1, 2, 16'h0000, "R6");
    step(); step();
    cnt = 16'h0100; modeCapture = 0; step();

    // R7 pinA decode (inverted), R9 latency
    capTest(0, 0, 1'b1, 2'b00, 1'b1, "R7 R9 rise code00");
    capTest(0, 0, 1'b0, 2'b00, 1'b0, "R7 fall code00");
    capTest(0, 0, 1'b0, 2'b01, 1'b1, "R7 fall code01");
    capTest(0, 0, 1'b1, 2'b01, 1'b0, "R7 rise code01");
    capTest(0, 0, 1'b1, 2'b10, 1'b0, "R7 rise code10");
    capTest(0, 0, 1'b1, 2'b11, 1'b0, "R7 rise code11");
    capTest(0, 0, 1'b0, 2'b11, 1'b0, "R7 fall code11");

    // R8 pinB decode (direct)
    capTest(1, 1, 1'b0, 2'b00, 1'b1, "R8 fall code00");
    capTest(1, 1, 1'b1, 2'b00, 1'b0, "R8 rise code00");
    capTest(1, 1, 1'b1, 2'b01, 1'b1, "R8 R9 rise code01");
    capTest(1, 1, 1'b0, 2'b10, 1'b0, "R8 fall code10");
    capTest(1, 1, 1'b1, 2'b11, 1'b1, "R8 rise code11");
    capTest(1, 1, 1'b0, 2'b11, 1'b1, "R8 fall code11");

    // R10 unselected pin ignored
    capTest(1, 0, 1'b1, 2'b00, 1'b0, "R10 pinA while pinB selected");
    capTest(0, 1, 1'b1, 2'b01, 1'b0, "R10 pinB while pinA selected");

    repeat (4) step();
    if (sb.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule